// File: doc/BRIEF.md
# Multi-channel trace packet serializer

This block is a debug tracer with three trace channels that share one serial output. Software writes up to four 16-bit parameters for a channel. It then writes that channel's command word, which holds a header byte and a parameter count. That one write both loads the packet and asks for it to be sent. A fixed-priority arbiter picks one pending channel. The block then sends the header byte, an optional 16-bit timestamp and the selected parameters on a serial data line, most significant bit first.

The bit rate comes from a prescaler that divides the system clock by 1, 2, 3 or 4. A bit strobe marks the last system cycle of each bit period, and a frame signal covers the packet exactly. A free-running transmit timer counts bit ticks while timestamping is on. Software can clear the timer, and its value is captured when each packet starts.

A simple word-addressed write/read bus gives access to the registers. Reads are combinational on the address.

Top module: `trace_serializer`

## Requirements
- R1: After reset every register (word addresses 0 to 9) reads 0, and ser_data, ser_bclk and ser_frame are low.
- R2: Parameter words sit at addresses 4+c (params 0 and 1) and 7+c (params 2 and 3) for channel c = 0..2. The lower parameter is in bits 15:0 and the higher one in bits 31:16. Each word reads back as written.
- R3: A write to the command word at address 1+c puts the header in bits 15:8 and the count in bits 2:0, and starts a packet. The packet's first 8 bits are the header, MSB first, and ser_data is sampled in cycles where ser_bclk is high.
- R4: After the header (and timestamp, if on), parameters 0 to n-1 follow, MSB first, where n is the count. A count of 5 to 7 sends all four parameters.
- R5: A command word reads back as written while its packet is pending or being sent, and reads 0 once the packet has ended. A command write to a channel that is still busy is ignored.
- R6: Configuration bit 4 enables channel 0. Bits 6:5 and 8:7 are the 2-bit modes of channels 1 and 2: 0 = off, and any nonzero value (including the alternate-source code 2) = enabled. A command write to a channel that is off starts no packet and leaves its command word reading 0.
- R7: When several channels are pending, the lowest-numbered channel is sent first. A packet that has started runs to its end, whatever requests arrive.
- R8: Configuration bits 1:0 set the bit period: code k gives k+1 system cycles per bit. ser_bclk pulses once per bit, only while ser_frame is high.
- R9: When configuration bit 2 is set, a 16-bit timestamp follows the header. The timestamp is the number of bit ticks counted since the last timer clear, taken at the cycle the frame starts.
- R10: Writing 1 to configuration bit 3 resets the timer to 0. The bit reads back as 0, and the other configuration fields take the written values.
- R11: ser_frame is high for exactly (packet bits) x (bit period) cycles, and ser_data is low whenever ser_frame is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ser_data | output | 1 | Serial trace data, MSB first |
| ser_bclk | output | 1 | Bit strobe, high in the last cycle of each bit |
| ser_frame | output | 1 | High for the whole packet |

## Verification
The bench checks the packet length and content for counts of 0, 2 and the clamped value 7. A design that forgot the clamp would send stale or missing bits, and one that misordered parameters would swap whole 16-bit words. It writes three channels while one long packet is in flight. A design that preempted the running packet, or that used the wrong priority, would shorten the first packet or swap the next two headers. It measures frame length in cycles at every prescaler code, where an off-by-one in the divider shows up as a wrong count. It also checks exact timestamp values one cycle and six cycles after a clear, which catches a timer that counts from the wrong edge or ignores the clear.

// File: rtl/trace_pkg.sv
package trace_pkg;
    // Register word layout fixed by the bus map.
    localparam int BUS_DW        = 32;
    localparam int HDR_W         = 8;
    localparam int CNT_W         = 3;
    localparam int PAR_W         = 16;
    localparam int PAR_N         = 4;
    localparam int DIV_W         = 2;
    localparam int MODE_W        = 2;
    // Configuration word bit positions.
    localparam int CFG_DIV_LSB   = 0;
    localparam int CFG_TSEN_BIT  = 2;
    localparam int CFG_TSCLR_BIT = 3;
    localparam int CFG_EN0_BIT   = 4;
    localparam int CFG_MODE_LSB  = 5;
    // Command word bit positions.
    localparam int CMD_CNT_LSB   = 0;
    localparam int CMD_HDR_LSB   = 8;
endpackage

// File: rtl/trace_regs.sv
module trace_regs
    import trace_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 4
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         bus_wr,
    input  logic [ADDR_W-1:0]                            bus_addr,
    input  logic [BUS_DW-1:0]                            bus_wdata,
    output logic [BUS_DW-1:0]                            bus_rdata,
    input  logic [NUM_CH-1:0]                            done_i,
    output logic [DIV_W-1:0]                             div_o,
    output logic                                         ts_en_o,
    output logic                                         ts_clr_o,
    output logic [NUM_CH-1:0]                            pend_o,
    output logic [NUM_CH-1:0][HDR_W-1:0]                 hdr_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]                 cnt_o,
    output logic [NUM_CH-1:0][PAR_N-1:0][PAR_W-1:0]      par_o
);
    localparam int CMD_BASE = 1;
    localparam int P01_BASE = CMD_BASE + NUM_CH;
    localparam int P23_BASE = P01_BASE + NUM_CH;

    typedef struct packed {
        logic [DIV_W-1:0]                        div;
        logic                                    ts_en;
        logic [NUM_CH-1:0][MODE_W-1:0]           mode;
        logic [NUM_CH-1:0]                       pend;
        logic [NUM_CH-1:0][HDR_W-1:0]            hdr;
        logic [NUM_CH-1:0][CNT_W-1:0]            cnt;
        logic [NUM_CH-1:0][PAR_N-1:0][PAR_W-1:0] par;
    } regs_t;

    regs_t st_d, st_q;

    logic cfg_sel;
    assign cfg_sel = (bus_addr == '0);

    always_comb begin
        st_d = st_q;
        // A finished packet frees its channel.
        for (int c = 0; c < NUM_CH; c++) begin
            if (done_i[c]) begin
                st_d.pend[c] = 1'b0;
                st_d.hdr[c]  = '0;
                st_d.cnt[c]  = '0;
            end
        end
        if (bus_wr) begin
            if (cfg_sel) begin
                st_d.div   = bus_wdata[CFG_DIV_LSB +: DIV_W];
                st_d.ts_en = bus_wdata[CFG_TSEN_BIT];
                for (int c = 0; c < NUM_CH; c++) begin
                    if (c == 0) begin
                        st_d.mode[c] = {1'b0, bus_wdata[CFG_EN0_BIT]};
                    end else begin
                        st_d.mode[c] = bus_wdata[CFG_MODE_LSB + 2*c - 2 +: MODE_W];
                    end
                end
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (bus_addr == ADDR_W'(CMD_BASE + c)) begin
                    if ((st_q.mode[c] != '0) && !st_q.pend[c]) begin
                        st_d.pend[c] = 1'b1;
                        st_d.hdr[c]  = bus_wdata[CMD_HDR_LSB +: HDR_W];
                        st_d.cnt[c]  = bus_wdata[CMD_CNT_LSB +: CNT_W];
                    end
                end
                if (bus_addr == ADDR_W'(P01_BASE + c)) begin
                    st_d.par[c][0] = bus_wdata[PAR_W-1:0];
                    st_d.par[c][1] = bus_wdata[2*PAR_W-1:PAR_W];
                end
                if (bus_addr == ADDR_W'(P23_BASE + c)) begin
                    st_d.par[c][2] = bus_wdata[PAR_W-1:0];
                    st_d.par[c][3] = bus_wdata[2*PAR_W-1:PAR_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (cfg_sel) begin
            bus_rdata[CFG_DIV_LSB +: DIV_W] = st_q.div;
            bus_rdata[CFG_TSEN_BIT]         = st_q.ts_en;
            for (int c = 0; c < NUM_CH; c++) begin
                if (c == 0) begin
                    bus_rdata[CFG_EN0_BIT] = st_q.mode[c][0];
                end else begin
                    bus_rdata[CFG_MODE_LSB + 2*c - 2 +: MODE_W] = st_q.mode[c];
                end
            end
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(CMD_BASE + c)) begin
                bus_rdata[CMD_HDR_LSB +: HDR_W] = st_q.hdr[c];
                bus_rdata[CMD_CNT_LSB +: CNT_W] = st_q.cnt[c];
            end
            if (bus_addr == ADDR_W'(P01_BASE + c)) begin
                bus_rdata = {st_q.par[c][1], st_q.par[c][0]};
            end
            if (bus_addr == ADDR_W'(P23_BASE + c)) begin
                bus_rdata = {st_q.par[c][3], st_q.par[c][2]};
            end
        end
    end

    assign div_o    = st_q.div;
    assign ts_en_o  = st_q.ts_en;
    assign ts_clr_o = bus_wr && cfg_sel && bus_wdata[CFG_TSCLR_BIT];
    assign pend_o   = st_q.pend;
    assign hdr_o    = st_q.hdr;
    assign cnt_o    = st_q.cnt;
    assign par_o    = st_q.par;
endmodule

// File: rtl/trace_timebase.sv
module trace_timebase
    import trace_pkg::*;
#(
    parameter int TS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              ts_en_i,
    input  logic              ts_clr_i,
    output logic              tick_o,
    output logic [TS_W-1:0]   timer_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [TS_W-1:0]  timer;
    } tb_t;

    tb_t tb_d, tb_q;
    logic tick;

    // Code k ends a bit period after k+1 cycles; a shrinking code ends it at once.
    assign tick = (tb_q.cnt >= div_i);

    always_comb begin
        tb_d = tb_q;
        tb_d.cnt = tick ? '0 : tb_q.cnt + 1'b1;
        if (ts_clr_i) begin
            tb_d.timer = '0;
        end else if (ts_en_i && tick) begin
            tb_d.timer = tb_q.timer + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_q <= '0;
        end else begin
            tb_q <= tb_d;
        end
    end

    assign tick_o  = tick;
    assign timer_o = tb_q.timer;
endmodule

// File: rtl/trace_shifter.sv
module trace_shifter
    import trace_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int TS_W   = 16
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     tick_i,
    input  logic                                     ts_en_i,
    input  logic [TS_W-1:0]                          timer_i,
    input  logic [NUM_CH-1:0]                        pend_i,
    input  logic [NUM_CH-1:0][HDR_W-1:0]             hdr_i,
    input  logic [NUM_CH-1:0][CNT_W-1:0]             cnt_i,
    input  logic [NUM_CH-1:0][PAR_N-1:0][PAR_W-1:0]  par_i,
    output logic [NUM_CH-1:0]                        done_o,
    output logic                                     ser_data_o,
    output logic                                     ser_bclk_o,
    output logic                                     ser_frame_o
);
    localparam int PAY_W = PAR_N * PAR_W;
    localparam int SH_W  = HDR_W + TS_W + PAY_W;
    localparam int LEN_W = $clog2(SH_W + 1);
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic             busy;
        logic [CH_W-1:0]  ch;
        logic [SH_W-1:0]  sh;
        logic [LEN_W-1:0] left;
    } shf_t;

    shf_t sf_d, sf_q;

    logic             found;
    logic [CH_W-1:0]  sel;
    logic [CNT_W-1:0] nsel;
    logic [PAY_W-1:0] payload;
    int               nbits;

    // Fixed priority: the lowest pending index wins.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (pend_i[c]) begin
                found = 1'b1;
                sel   = CH_W'(c);
            end
        end
    end

    always_comb begin
        nsel = (cnt_i[sel] > CNT_W'(PAR_N)) ? CNT_W'(PAR_N) : cnt_i[sel];
        for (int k = 0; k < PAR_N; k++) begin
            payload[(PAR_N - 1 - k) * PAR_W +: PAR_W] = par_i[sel][k];
        end
        nbits = HDR_W + int'(nsel) * PAR_W + (ts_en_i ? TS_W : 0);
    end

    always_comb begin
        sf_d = sf_q;
        if (!sf_q.busy) begin
            if (tick_i && found) begin
                sf_d.busy = 1'b1;
                sf_d.ch   = sel;
                sf_d.left = LEN_W'(nbits);
                if (ts_en_i) begin
                    sf_d.sh = {hdr_i[sel], timer_i, payload};
                end else begin
                    sf_d.sh = {hdr_i[sel], payload, {TS_W{1'b0}}};
                end
            end
        end else if (tick_i) begin
            if (sf_q.left == LEN_W'(1)) begin
                sf_d.busy = 1'b0;
            end else begin
                sf_d.sh   = sf_q.sh << 1;
                sf_d.left = sf_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sf_q <= '0;
        end else begin
            sf_q <= sf_d;
        end
    end

    assign done_o = (sf_q.busy && tick_i && (sf_q.left == LEN_W'(1)))
                    ? (NUM_CH'(1) << sf_q.ch) : '0;
    assign ser_data_o  = sf_q.busy & sf_q.sh[SH_W-1];
    assign ser_bclk_o  = sf_q.busy & tick_i;
    assign ser_frame_o = sf_q.busy;
endmodule

// File: rtl/trace_serializer.sv
module trace_serializer
    import trace_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int TS_W   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        ser_data,
    output logic        ser_bclk,
    output logic        ser_frame
);
    logic [DIV_W-1:0]                        div;
    logic                                    ts_en;
    logic                                    ts_clr;
    logic                                    tick;
    logic [TS_W-1:0]                         timer;
    logic [NUM_CH-1:0]                       pend;
    logic [NUM_CH-1:0]                       done;
    logic [NUM_CH-1:0][HDR_W-1:0]            hdr;
    logic [NUM_CH-1:0][CNT_W-1:0]            cnt;
    logic [NUM_CH-1:0][PAR_N-1:0][PAR_W-1:0] par;

    trace_regs #(.NUM_CH(NUM_CH), .ADDR_W(4)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_i(done),
        .div_o(div), .ts_en_o(ts_en), .ts_clr_o(ts_clr), .pend_o(pend),
        .hdr_o(hdr), .cnt_o(cnt), .par_o(par)
    );

    trace_timebase #(.TS_W(TS_W)) u_time (
        .clk(clk), .rst_n(rst_n), .div_i(div), .ts_en_i(ts_en),
        .ts_clr_i(ts_clr), .tick_o(tick), .timer_o(timer)
    );

    trace_shifter #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .ts_en_i(ts_en),
        .timer_i(timer), .pend_i(pend), .hdr_i(hdr), .cnt_i(cnt),
        .par_i(par), .done_o(done), .ser_data_o(ser_data),
        .ser_bclk_o(ser_bclk), .ser_frame_o(ser_frame)
    );
endmodule

// File: rtl/trace_serializer_chk.sv
module trace_serializer_chk #(
    parameter int NUM_CH = 3,
    parameter int TS_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_data,
    input logic              ser_bclk,
    input logic              ser_frame,
    input logic              tick,
    input logic [TS_W-1:0]   timer,
    input logic              ts_clr,
    input logic [NUM_CH-1:0] done,
    input logic [NUM_CH-1:0] pend
);
    p_bclk_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ser_bclk |-> ser_frame);

    p_start_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_frame) |-> $past(tick));

    p_idle_data_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_frame |-> !ser_data);

    p_done_ends_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |=> !ser_frame);

    p_single_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));

    p_frame_has_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ser_frame |-> (|pend));

    p_done_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |=> ((pend & $past(done)) == '0));

    p_timer_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ts_clr |=> (timer == '0));
endmodule

bind trace_serializer trace_serializer_chk #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_bclk(ser_bclk),
    .ser_frame(ser_frame), .tick(tick), .timer(timer), .ts_clr(ts_clr),
    .done(done), .pend(pend)
);

// File: tb/trace_serializer_tb.sv
module trace_serializer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ser_data, ser_bclk, ser_frame;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    trace_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_data(ser_data),
        .ser_bclk(ser_bclk), .ser_frame(ser_frame)
    );

    // Packet monitor.
    logic [127:0] pk_bits [32];
    int           pk_len  [32];
    int           pk_cyc  [32];
    int           pk_cnt = 0;
    logic [127:0] cur = '0;
    int           cur_n = 0;
    int           cur_c = 0;
    logic         prev_f = 1'b0;

    always @(negedge clk) begin
        if (ser_frame) begin
            cur_c = cur_c + 1;
            if (ser_bclk) begin
                cur   = {cur[126:0], ser_data};
                cur_n = cur_n + 1;
            end
        end else if (prev_f) begin
            if (pk_cnt < 32) begin
                pk_bits[pk_cnt] = cur;
                pk_len[pk_cnt]  = cur_n;
                pk_cyc[pk_cnt]  = cur_c;
            end
            pk_cnt = pk_cnt + 1;
            cur = '0; cur_n = 0; cur_c = 0;
        end
        prev_f = ser_frame;
    end

    localparam logic [31:0] EN_ALL = 32'h130; // ch0 on, ch1 mode 1, ch2 mode 2
    localparam logic [31:0] TSEN   = 32'h4;
    localparam logic [31:0] TSCLR  = 32'h8;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_pk(input int n);
        for (int i = 0; i < 5000 && pk_cnt < n; i++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        bit ok = 1;
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), v);
            if (v != 0) ok = 0;
        end
        chk(ok, "R1 regs zero", {127'b0, ok}, 1);
        chk({ser_data, ser_bclk, ser_frame} == 3'b0, "R1 outputs low",
            {ser_data, ser_bclk, ser_frame}, 0);
    endtask

    task automatic t_params;
        logic [31:0] v;
        wr(4'd5, 32'hBEEF_1234);
        wr(4'd8, 32'h55AA_0F0F);
        rd(4'd5, v); chk(v == 32'hBEEF_1234, "R2 p01 ch1", v, 32'hBEEF_1234);
        rd(4'd8, v); chk(v == 32'h55AA_0F0F, "R2 p23 ch1", v, 32'h55AA_0F0F);
    endtask

    task automatic t_header_only;
        int b = pk_cnt;
        wr(4'd0, EN_ALL);
        wr(4'd1, 32'h0000_A500);
        wait_pk(b + 1);
        chk(pk_len[b] == 8, "R3 header length", pk_len[b], 8);
        chk(pk_bits[b][7:0] == 8'hA5, "R3 header bits", pk_bits[b], 8'hA5);
        chk(pk_cyc[b] == 8, "R11 frame cycles div1", pk_cyc[b], 8);
    endtask

    task automatic t_params_packet;
        int b = pk_cnt;
        logic [71:0] e4;
        wr(4'd4, 32'h2222_1111);
        wr(4'd7, 32'h4444_3333);
        wr(4'd1, 32'h0000_C302);
        wait_pk(b + 1);
        chk(pk_len[b] == 40, "R4 count 2 length", pk_len[b], 40);
        chk(pk_bits[b][39:0] == 40'hC3_1111_2222, "R4 count 2 bits",
            pk_bits[b][39:0], 40'hC3_1111_2222);
        idle(3);
        wr(4'd1, 32'h0000_9907);
        wait_pk(b + 2);
        e4 = 72'h99_1111_2222_3333_4444;
        chk(pk_len[b+1] == 72, "R4 clamp length", pk_len[b+1], 72);
        chk(pk_bits[b+1][71:0] == e4, "R4 clamp bits", pk_bits[b+1][71:0], e4);
    endtask

    task automatic t_cmd_readback;
        int b = pk_cnt;
        logic [31:0] v;
        wr(4'd0, EN_ALL | 32'h3);
        wr(4'd1, 32'h0000_3C01);
        rd(4'd1, v); chk(v == 32'h3C01, "R5 busy readback", v, 32'h3C01);
        wr(4'd1, 32'h0000_7702);
        rd(4'd1, v); chk(v == 32'h3C01, "R5 write while busy ignored", v, 32'h3C01);
        wait_pk(b + 1);
        idle(40);
        rd(4'd1, v); chk(v == 0, "R5 cleared after packet", v, 0);
        chk(pk_cnt == b + 1, "R5 one packet only", pk_cnt - b, 1);
        chk(pk_bits[b][23:16] == 8'h3C, "R5 first header kept", pk_bits[b][23:16], 8'h3C);
        chk(pk_cyc[b] == 24 * 4, "R8 frame cycles div4", pk_cyc[b], 96);
    endtask

    task automatic t_disabled;
        int b = pk_cnt;
        logic [31:0] v;
        wr(4'd0, 32'h100);          // ch0 off, ch1 off, ch2 mode 2
        wr(4'd2, 32'h0000_5501);
        wr(4'd1, 32'h0000_6601);
        idle(40);
        chk(pk_cnt == b, "R6 disabled no packet", pk_cnt - b, 0);
        rd(4'd2, v); chk(v == 0, "R6 disabled ch1 cmd reads 0", v, 0);
        rd(4'd1, v); chk(v == 0, "R6 disabled ch0 cmd reads 0", v, 0);
    endtask

    task automatic t_priority;
        int b = pk_cnt;
        wr(4'd0, EN_ALL);
        wr(4'd1, 32'h0000_F004);
        wr(4'd3, 32'h0000_2200);
        wr(4'd2, 32'h0000_1100);
        wait_pk(b + 3);
        chk(pk_len[b] == 72, "R7 first packet not cut", pk_len[b], 72);
        chk(pk_bits[b][71:64] == 8'hF0, "R7 ch0 first", pk_bits[b][71:64], 8'hF0);
        chk(pk_bits[b+1][7:0] == 8'h11, "R7 ch1 before ch2", pk_bits[b+1][7:0], 8'h11);
        chk(pk_bits[b+2][7:0] == 8'h22, "R7 ch2 last (mode 2 on) R6",
            pk_bits[b+2][7:0], 8'h22);
    endtask

    task automatic t_prescale;
        for (int k = 1; k < 3; k++) begin
            int b = pk_cnt;
            wr(4'd0, EN_ALL | 32'(k));
            wr(4'd1, 32'h0000_8100);
            wait_pk(b + 1);
            chk(pk_cyc[b] == 8 * (k + 1), "R8 bit period", pk_cyc[b], 8 * (k + 1));
            chk(pk_len[b] == 8, "R8 one strobe per bit", pk_len[b], 8);
            idle(8);
        end
    endtask

    task automatic t_timestamp;
        int b = pk_cnt;
        logic [31:0] v;
        wr(4'd4, 32'h0000_ABCD);
        wr(4'd0, EN_ALL | TSEN | TSCLR);
        wr(4'd1, 32'h0000_5A01);
        wait_pk(b + 1);
        chk(pk_len[b] == 40, "R9 length with stamp", pk_len[b], 40);
        chk(pk_bits[b][39:0] == 40'h5A_0001_ABCD, "R9 stamp one tick",
            pk_bits[b][39:0], 40'h5A_0001_ABCD);
        rd(4'd0, v); chk(v == (EN_ALL | TSEN), "R10 clear bit reads 0", v, EN_ALL | TSEN);
        wr(4'd0, EN_ALL | TSEN | TSCLR);
        idle(5);
        wr(4'd1, 32'h0000_5A01);
        wait_pk(b + 2);
        chk(pk_bits[b+1][39:0] == 40'h5A_0006_ABCD, "R10 stamp after clear",
            pk_bits[b+1][39:0], 40'h5A_0006_ABCD);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_params;
        t_header_only;
        t_params_packet;
        t_cmd_readback;
        t_disabled;
        t_priority;
        t_prescale;
        t_timestamp;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule